// File: doc/BRIEF.md
# Received interrupt and message collector

This block sits between a link-side receive path that has already decoded incoming interrupt and message events and a host CPU that services them through a simple word-addressed register bus. Each event arrives as one valid cycle carrying a kind, an 8-bit code, a 64-bit address and a 32-bit data word. Messages are queued in a 128-entry FIFO. Software inspects the oldest queued entry through a set of field registers and then discards it by writing a pop register.

MSI events take one of two paths, chosen by a configuration bit. They can be queued in the FIFO like messages, or they can set one of 64 sticky vector bits. In the second case vectors 0 to 31 feed one interrupt output and vectors 32 to 63 feed another. Legacy interrupts (four lines) and DMA-channel completions (four channels) always set sticky status bits. FIFO overflow sets a bit in a miscellaneous status register. Every status register has a mask of the same width, and each of the five interrupt outputs is a registered level that is high while any masked status bit in its group is set.

The register bus uses a write strobe, a 5-bit word address and 32-bit write data. Read data is a combinational function of the address, and a read has no side effects.

Top module: `rxevt_collector`

## Requirements
- R1: After reset the FIFO level is 0. All status, mask and configuration registers are 0 and all five interrupt outputs are low. While the FIFO is empty, the head field registers (addresses 2 to 6) read 0.
- R2: An event with `ev_kind`=0 (message) is queued. The head registers show the oldest entry: kind at address 2, code at 3, address bits 31:0 at 4, address bits 63:32 at 5, data at 6. Entries come out in arrival order, and address 1 reads the number of queued entries.
- R3: Reading any register never changes the FIFO level or the head entry.
- R4: A write to address 7 removes the head entry. Such a write while the FIFO is empty is ignored, and the level stays 0.
- R5: When configuration bit 0 (address 0) is 1, an MSI event (`ev_kind`=1) is queued with kind 1 and leaves both MSI status registers unchanged.
- R6: When configuration bit 0 is 0, an MSI event with vector v = `ev_data[5:0]` is not queued. For v below 32 it sets bit v of address 8; otherwise it sets bit v-32 of address 9.
- R7: The MSI masks are at addresses 10 (vectors 0–31) and 11 (vectors 32–63). `irq_msi_lo` is high only while address 8 AND address 10 is nonzero, and `irq_msi_hi` likewise for addresses 9 and 11. The two outputs are independent.
- R8: A legacy event (`ev_kind`=2) sets bit `ev_code[1:0]` of address 12. `irq_legacy` is the OR of all four bits of address 12 AND its mask at address 13.
- R9: A DMA event (`ev_kind`=3) sets bit `ev_code[1:0]` of address 14. `irq_dma` is high while address 14 AND its mask at address 15 is nonzero.
- R10: Status bits are sticky and are cleared by writing 1 to the bit position of the status register. A bit that is set by an event and cleared in the same cycle remains set.
- R11: An event that would be queued while 128 entries are held is dropped, and it sets bit 0 of address 16. `irq_misc` is high while that bit AND mask bit 0 at address 17 is set.
- R12: Each interrupt output is registered. It changes on the clock edge after the edge that changed its status or mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_valid | input | 1 | Received event present this cycle |
| ev_kind | input | 2 | 0 message, 1 MSI, 2 legacy, 3 DMA |
| ev_code | input | 8 | Message code, or legacy line / DMA channel in bits 1:0 |
| ev_addr | input | 64 | Event address |
| ev_data | input | 32 | Event data; MSI vector in bits 5:0 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq_msi_lo | output | 1 | Interrupt for MSI vectors 0–31 |
| irq_msi_hi | output | 1 | Interrupt for MSI vectors 32–63 |
| irq_legacy | output | 1 | Legacy interrupt |
| irq_dma | output | 1 | DMA-channel interrupt |
| irq_misc | output | 1 | Miscellaneous (overflow) interrupt |

## Verification
The bench fills the FIFO to exactly 128 entries and offers one more. A design with an off-by-one full flag would either keep a 129th entry or drop the 128th; the scoreboard would then see a wrong level or a mismatched entry during the drain. It pops an empty FIFO and then queues one entry, which exposes a pointer that slipped and so shows a stale or shifted head. It sets and clears the same legacy bit in one cycle to catch a clear that wins over the set. It also checks each interrupt output on both sides of its one-cycle register delay, and steers MSI vectors 5 and 40 to catch a wrong split between the two MSI outputs.

// File: rtl/rxevt_pkg.sv
// Shared types and register word addresses for the received event collector.
// Assumes a 32-bit register bus with 5-bit word addresses.
package rxevt_pkg;
    typedef enum logic [1:0] {
        EV_MSG = 2'd0,
        EV_MSI = 2'd1,
        EV_LEG = 2'd2,
        EV_DMA = 2'd3
    } ev_kind_e;

    typedef struct packed {
        logic [1:0]  kind;
        logic [7:0]  code;
        logic [63:0] addr;
        logic [31:0] data;
    } fifo_ent_t;

    localparam logic [4:0] A_CFG       = 5'd0;
    localparam logic [4:0] A_LEVEL     = 5'd1;
    localparam logic [4:0] A_HKIND     = 5'd2;
    localparam logic [4:0] A_HCODE     = 5'd3;
    localparam logic [4:0] A_HADDR_LO  = 5'd4;
    localparam logic [4:0] A_HADDR_HI  = 5'd5;
    localparam logic [4:0] A_HDATA     = 5'd6;
    localparam logic [4:0] A_POP       = 5'd7;
    localparam logic [4:0] A_MSI_ST_LO = 5'd8;
    localparam logic [4:0] A_MSI_MK_LO = 5'd10;
    localparam logic [4:0] A_LEG_ST    = 5'd12;
    localparam logic [4:0] A_LEG_MK    = 5'd13;
    localparam logic [4:0] A_DMA_ST    = 5'd14;
    localparam logic [4:0] A_DMA_MK    = 5'd15;
    localparam logic [4:0] A_MISC_ST   = 5'd16;
    localparam logic [4:0] A_MISC_MK   = 5'd17;
endpackage

// File: rtl/rxevt_fifo.sv
// Event FIFO: stores queued entries in arrival order and exposes the head.
// Assumes DEPTH is a power of two; a push when full and a pop when empty
// are both ignored (the caller flags the dropped push).
module rxevt_fifo
    import rxevt_pkg::*;
#(
    parameter int DEPTH = 128
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   push,
    input  fifo_ent_t              push_ent,
    input  logic                   pop,
    output fifo_ent_t              head_o,
    output logic [$clog2(DEPTH):0] level_o,
    output logic                   full_o,
    output logic                   empty_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = AW + 1;

    fifo_ent_t      mem [DEPTH];
    logic [AW-1:0]  wr_ptr, rd_ptr;
    logic [LW-1:0]  count;
    logic           do_push, do_pop;

    assign full_o  = (count == LW'(DEPTH));
    assign empty_o = (count == '0);
    assign do_push = push && !full_o;
    assign do_pop  = pop && !empty_o;
    assign head_o  = mem[rd_ptr];
    assign level_o = count;

    // Write an accepted entry into storage.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_ent;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rxevt_stat_bank.sv
// Status/mask pair with a registered interrupt: sticky status bits set by
// events, cleared by write-one; a set wins over a clear in the same cycle.
// Assumes W is at most 32 (register data width).
module rxevt_stat_bank #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_we,
    input  logic [W-1:0] clr_i,
    input  logic         mask_we,
    input  logic [W-1:0] mask_i,
    output logic [W-1:0] status_o,
    output logic [W-1:0] mask_o,
    output logic         irq_o
);
    logic [W-1:0] clr_eff;

    assign clr_eff = clr_we ? clr_i : '0;

    // Update status, mask and the registered interrupt level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_o <= '0;
            mask_o   <= '0;
            irq_o    <= 1'b0;
        end else begin
            status_o <= (status_o & ~clr_eff) | set_i;
            if (mask_we) mask_o <= mask_i;
            irq_o    <= |(status_o & mask_o);
        end
    end
endmodule

// File: rtl/rxevt_collector.sv
// Received interrupt and message collector top: routes decoded events to
// the FIFO or to status banks, decodes register writes and muxes reads.
// Assumes MSI_VEC/2 <= 32 and LEG_N, DMA_N powers of two no wider than 8.
module rxevt_collector
    import rxevt_pkg::*;
#(
    parameter int DEPTH   = 128,
    parameter int MSI_VEC = 64,
    parameter int LEG_N   = 4,
    parameter int DMA_N   = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ev_valid,
    input  logic [1:0]  ev_kind,
    input  logic [7:0]  ev_code,
    input  logic [63:0] ev_addr,
    input  logic [31:0] ev_data,
    input  logic        reg_wr,
    input  logic [4:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq_msi_lo,
    output logic        irq_msi_hi,
    output logic        irq_legacy,
    output logic        irq_dma,
    output logic        irq_misc
);
    localparam int MSI_HALF = MSI_VEC / 2;
    localparam int MSI_IW   = $clog2(MSI_VEC);
    localparam int LEG_IW   = $clog2(LEG_N);
    localparam int DMA_IW   = $clog2(DMA_N);
    localparam int LW       = $clog2(DEPTH) + 1;

    logic                cfg_msi_fifo;
    logic                push_req, pop_req, fifo_full, fifo_empty;
    fifo_ent_t           head, push_ent;
    logic [LW-1:0]       fifo_level;
    logic [MSI_VEC-1:0]  msi_set;
    logic [LEG_N-1:0]    leg_set, leg_st, leg_mk;
    logic [DMA_N-1:0]    dma_set, dma_st, dma_mk;
    logic [0:0]          misc_set, misc_st, misc_mk;
    logic [MSI_HALF-1:0] msi_st [2];
    logic [MSI_HALF-1:0] msi_mk [2];
    logic [1:0]          msi_irq;

    assign push_req = ev_valid && (ev_kind == EV_MSG || (ev_kind == EV_MSI && cfg_msi_fifo));
    assign pop_req  = reg_wr && reg_addr == A_POP;
    assign push_ent = '{kind: ev_kind, code: ev_code, addr: ev_addr, data: ev_data};
    assign misc_set = push_req && fifo_full;

    // Configuration register: bit 0 steers MSI into the FIFO.
    always_ff @(posedge clk) begin
        if (!rst_n)                         cfg_msi_fifo <= 1'b0;
        else if (reg_wr && reg_addr == A_CFG) cfg_msi_fifo <= reg_wdata[0];
    end

    // Decode event vectors into one-hot status set requests.
    always_comb begin
        msi_set = '0;
        leg_set = '0;
        dma_set = '0;
        if (ev_valid && ev_kind == EV_MSI && !cfg_msi_fifo) msi_set[ev_data[MSI_IW-1:0]] = 1'b1;
        if (ev_valid && ev_kind == EV_LEG) leg_set[ev_code[LEG_IW-1:0]] = 1'b1;
        if (ev_valid && ev_kind == EV_DMA) dma_set[ev_code[DMA_IW-1:0]] = 1'b1;
    end

    rxevt_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push_req), .push_ent(push_ent), .pop(pop_req),
        .head_o(head), .level_o(fifo_level), .full_o(fifo_full), .empty_o(fifo_empty)
    );

    for (genvar g = 0; g < 2; g++) begin : g_msi
        rxevt_stat_bank #(.W(MSI_HALF)) u_bank (
            .clk(clk), .rst_n(rst_n), .set_i(msi_set[g*MSI_HALF +: MSI_HALF]),
            .clr_we(reg_wr && reg_addr == A_MSI_ST_LO + 5'(g)), .clr_i(reg_wdata[MSI_HALF-1:0]),
            .mask_we(reg_wr && reg_addr == A_MSI_MK_LO + 5'(g)), .mask_i(reg_wdata[MSI_HALF-1:0]),
            .status_o(msi_st[g]), .mask_o(msi_mk[g]), .irq_o(msi_irq[g])
        );
    end

    rxevt_stat_bank #(.W(LEG_N)) u_leg (
        .clk(clk), .rst_n(rst_n), .set_i(leg_set),
        .clr_we(reg_wr && reg_addr == A_LEG_ST), .clr_i(reg_wdata[LEG_N-1:0]),
        .mask_we(reg_wr && reg_addr == A_LEG_MK), .mask_i(reg_wdata[LEG_N-1:0]),
        .status_o(leg_st), .mask_o(leg_mk), .irq_o(irq_legacy)
    );

    rxevt_stat_bank #(.W(DMA_N)) u_dma (
        .clk(clk), .rst_n(rst_n), .set_i(dma_set),
        .clr_we(reg_wr && reg_addr == A_DMA_ST), .clr_i(reg_wdata[DMA_N-1:0]),
        .mask_we(reg_wr && reg_addr == A_DMA_MK), .mask_i(reg_wdata[DMA_N-1:0]),
        .status_o(dma_st), .mask_o(dma_mk), .irq_o(irq_dma)
    );

    rxevt_stat_bank #(.W(1)) u_misc (
        .clk(clk), .rst_n(rst_n), .set_i(misc_set),
        .clr_we(reg_wr && reg_addr == A_MISC_ST), .clr_i(reg_wdata[0:0]),
        .mask_we(reg_wr && reg_addr == A_MISC_MK), .mask_i(reg_wdata[0:0]),
        .status_o(misc_st), .mask_o(misc_mk), .irq_o(irq_misc)
    );

    assign irq_msi_lo = msi_irq[0];
    assign irq_msi_hi = msi_irq[1];

    // Register read multiplexer; head fields read zero when empty.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CFG:           reg_rdata[0] = cfg_msi_fifo;
            A_LEVEL:         reg_rdata = 32'(fifo_level);
            A_HKIND:         if (!fifo_empty) reg_rdata = 32'(head.kind);
            A_HCODE:         if (!fifo_empty) reg_rdata = 32'(head.code);
            A_HADDR_LO:      if (!fifo_empty) reg_rdata = head.addr[31:0];
            A_HADDR_HI:      if (!fifo_empty) reg_rdata = head.addr[63:32];
            A_HDATA:         if (!fifo_empty) reg_rdata = head.data;
            A_MSI_ST_LO:     reg_rdata = 32'(msi_st[0]);
            A_MSI_ST_LO + 1: reg_rdata = 32'(msi_st[1]);
            A_MSI_MK_LO:     reg_rdata = 32'(msi_mk[0]);
            A_MSI_MK_LO + 1: reg_rdata = 32'(msi_mk[1]);
            A_LEG_ST:        reg_rdata = 32'(leg_st);
            A_LEG_MK:        reg_rdata = 32'(leg_mk);
            A_DMA_ST:        reg_rdata = 32'(dma_st);
            A_DMA_MK:        reg_rdata = 32'(dma_mk);
            A_MISC_ST:       reg_rdata = 32'(misc_st);
            A_MISC_MK:       reg_rdata = 32'(misc_mk);
            default:         reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/rxevt_checker.sv
// Property checker for rxevt_collector, attached by bind below.
// Assumes the top's internal names for FIFO level/flags and status banks.
module rxevt_checker
    import rxevt_pkg::*;
#(
    parameter int DEPTH    = 128,
    parameter int MSI_HALF = 32,
    parameter int LEG_N    = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   ev_valid,
    input logic [1:0]             ev_kind,
    input logic                   reg_wr,
    input logic [4:0]             reg_addr,
    input logic                   cfg_msi_fifo,
    input logic [$clog2(DEPTH):0] level,
    input logic                   full,
    input logic                   empty,
    input logic [0:0]             misc_st,
    input logic [LEG_N-1:0]       leg_st,
    input logic [MSI_HALF-1:0]    msi_st_lo,
    input logic [MSI_HALF-1:0]    msi_mk_lo,
    input logic                   irq_msi_lo
);
    localparam int LW = $clog2(DEPTH) + 1;

    // R2: occupancy never exceeds the capacity.
    a_r2_level_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));

    // R4: popping an empty FIFO with no arrival leaves it empty.
    a_r4_pop_empty_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !ev_valid && reg_wr && reg_addr == A_POP) |=> empty);

    // R11: an arriving message while full raises the overflow bit.
    a_r11_overflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (full && ev_valid && ev_kind == EV_MSG) |=> misc_st[0]);

    // R10: without a clear write, legacy status bits never fall.
    a_r10_sticky_legacy: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == A_LEG_ST) |=> ((leg_st & $past(leg_st)) == $past(leg_st)));

    // R7: low MSI interrupt only follows a masked, set vector.
    a_r7_msi_lo_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq_msi_lo |-> $past((msi_st_lo & msi_mk_lo) != '0));

    // R5: MSI routed to the FIFO leaves the low status untouched.
    a_r5_msi_fifo_path: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_kind == EV_MSI && cfg_msi_fifo && !reg_wr) |=> msi_st_lo == $past(msi_st_lo));
endmodule

bind rxevt_collector rxevt_checker #(
    .DEPTH(DEPTH), .MSI_HALF(MSI_VEC / 2), .LEG_N(LEG_N)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .cfg_msi_fifo(cfg_msi_fifo),
    .level(fifo_level), .full(fifo_full), .empty(fifo_empty),
    .misc_st(misc_st), .leg_st(leg_st), .msi_st_lo(msi_st[0]),
    .msi_mk_lo(msi_mk[0]), .irq_msi_lo(irq_msi_lo)
);

// File: tb/sim_rxevt_collector.sv
// Scoreboard bench: the event driver queues expected FIFO entries, the
// monitor task reads the head through the register bus and compares.
module sim_rxevt_collector;
    import rxevt_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 128;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        ev_valid = 1'b0;
    logic [1:0]  ev_kind = '0;
    logic [7:0]  ev_code = '0;
    logic [63:0] ev_addr = '0;
    logic [31:0] ev_data = '0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_msi_lo, irq_msi_hi, irq_legacy, irq_dma, irq_misc;

    int          nchk = 0, nfail = 0;
    bit          done = 1'b0;
    bit          cfg_m = 1'b0;
    fifo_ent_t   exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rxevt_collector u0 (.*);

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a == A_CFG) cfg_m = d[0];
    endtask

    // Driver: one event cycle, expected entry pushed when it should queue.
    task automatic evt(input logic [1:0] k, input logic [7:0] c, input logic [63:0] a, input logic [31:0] d);
        @(negedge clk);
        ev_valid = 1'b1; ev_kind = k; ev_code = c; ev_addr = a; ev_data = d;
        if ((k == 2'd0 || (k == 2'd1 && cfg_m)) && exp_q.size() < DEPTH)
            exp_q.push_back('{kind: k, code: c, addr: a, data: d});
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    // Monitor: compare head fields with the scoreboard, then pop.
    task automatic pop_check(input string req);
        fifo_ent_t   e;
        logic [31:0] d;
        if (exp_q.size() == 0) begin
            chk(req, "scoreboard_empty", 64'd1, 64'd0);
            return;
        end
        e = exp_q.pop_front();
        rd(A_HKIND, d);    chk(req, "head_kind", 64'(d), 64'(e.kind));
        rd(A_HCODE, d);    chk(req, "head_code", 64'(d), 64'(e.code));
        rd(A_HADDR_LO, d); chk(req, "head_addr_lo", 64'(d), 64'(e.addr[31:0]));
        rd(A_HADDR_HI, d); chk(req, "head_addr_hi", 64'(d), 64'(e.addr[63:32]));
        rd(A_HDATA, d);    chk(req, "head_data", 64'(d), 64'(e.data));
        wr(A_POP, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog R1 act=hung exp=finished");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state
        rd(A_LEVEL, d);   chk("R1", "level", 64'(d), 64'd0);
        rd(A_HDATA, d);   chk("R1", "head_data_empty", 64'(d), 64'd0);
        rd(A_LEG_ST, d);  chk("R1", "leg_status", 64'(d), 64'd0);
        rd(A_CFG, d);     chk("R1", "cfg", 64'(d), 64'd0);
        chk("R1", "irqs", {59'd0, irq_msi_lo, irq_msi_hi, irq_legacy, irq_dma, irq_misc}, 64'd0);

        // R2: three messages, order and fields
        evt(2'd0, 8'h14, 64'hDEAD_BEEF_0000_1000, 32'h1111_2222);
        evt(2'd0, 8'h7F, 64'h0000_0001_FFFF_FFFC, 32'hCAFE_F00D);
        evt(2'd0, 8'h00, 64'hA5A5_5A5A_0F0F_F0F0, 32'h0000_0000);
        rd(A_LEVEL, d);   chk("R2", "level_after_3", 64'(d), 64'd3);
        // R3: reads do not remove
        rd(A_HDATA, d);   chk("R3", "head_data_read1", 64'(d), 64'h1111_2222);
        rd(A_HDATA, d);   chk("R3", "head_data_read2", 64'(d), 64'h1111_2222);
        rd(A_LEVEL, d);   chk("R3", "level_after_reads", 64'(d), 64'd3);
        repeat (3) pop_check("R2");
        rd(A_LEVEL, d);   chk("R4", "level_after_pops", 64'(d), 64'd0);

        // R4: pop on empty ignored
        wr(A_POP, 32'd0);
        rd(A_LEVEL, d);   chk("R4", "level_empty_pop", 64'(d), 64'd0);
        evt(2'd0, 8'h33, 64'h0000_0000_1234_5678, 32'h8765_4321);
        rd(A_LEVEL, d);   chk("R4", "level_after_one", 64'(d), 64'd1);
        pop_check("R4");

        // R5: MSI into FIFO
        wr(A_CFG, 32'd1);
        evt(2'd1, 8'h00, 64'h0000_0000_FEE0_0000, 32'h0000_0007);
        rd(A_LEVEL, d);   chk("R5", "level_msi_queued", 64'(d), 64'd1);
        rd(A_MSI_ST_LO, d); chk("R5", "msi_status_lo", 64'(d), 64'd0);
        pop_check("R5");

        // R6: MSI into status, split by vector
        wr(A_CFG, 32'd0);
        evt(2'd1, 8'h00, 64'h0000_0000_FEE0_0000, 32'd5);
        evt(2'd1, 8'h00, 64'h0000_0000_FEE0_0000, 32'd40);
        rd(A_LEVEL, d);   chk("R6", "level_not_queued", 64'(d), 64'd0);
        rd(A_MSI_ST_LO, d); chk("R6", "msi_status_lo", 64'(d), 64'h20);
        rd(A_MSI_ST_LO + 5'd1, d); chk("R6", "msi_status_hi", 64'(d), 64'h100);

        // R7 / R12: masking and registered outputs
        chk("R7", "irq_lo_unmasked", 64'(irq_msi_lo), 64'd0);
        wr(A_MSI_MK_LO, 32'h20);
        chk("R12", "irq_lo_delay", 64'(irq_msi_lo), 64'd0);
        tick();
        chk("R7", "irq_lo_masked_on", 64'(irq_msi_lo), 64'd1);
        chk("R7", "irq_hi_independent", 64'(irq_msi_hi), 64'd0);
        wr(A_MSI_MK_LO + 5'd1, 32'h100);
        tick();
        chk("R7", "irq_hi_on", 64'(irq_msi_hi), 64'd1);
        wr(A_MSI_ST_LO, 32'h20);
        tick();
        chk("R10", "irq_lo_after_clear", 64'(irq_msi_lo), 64'd0);
        rd(A_MSI_ST_LO, d); chk("R10", "msi_lo_cleared", 64'(d), 64'd0);
        chk("R7", "irq_hi_unaffected", 64'(irq_msi_hi), 64'd1);

        // R8: legacy OR under mask
        wr(A_LEG_MK, 32'h4);
        evt(2'd2, 8'd0, 64'd0, 32'd0);
        tick();
        chk("R8", "irq_leg_masked_off", 64'(irq_legacy), 64'd0);
        evt(2'd2, 8'd2, 64'd0, 32'd0);
        chk("R12", "irq_leg_delay", 64'(irq_legacy), 64'd0);
        tick();
        chk("R8", "irq_leg_on", 64'(irq_legacy), 64'd1);
        rd(A_LEG_ST, d);  chk("R8", "leg_status", 64'(d), 64'h5);
        wr(A_LEG_ST, 32'h4);
        tick();
        chk("R8", "irq_leg_cleared", 64'(irq_legacy), 64'd0);

        // R10: set and clear in the same cycle
        @(negedge clk);
        ev_valid = 1'b1; ev_kind = 2'd2; ev_code = 8'd1;
        reg_wr = 1'b1; reg_addr = A_LEG_ST; reg_wdata = 32'h2;
        @(negedge clk);
        ev_valid = 1'b0; reg_wr = 1'b0;
        rd(A_LEG_ST, d);  chk("R10", "set_wins", 64'(d), 64'h3);
        wr(A_LEG_ST, 32'h1);
        rd(A_LEG_ST, d);  chk("R10", "w1c_single_bit", 64'(d), 64'h2);

        // R9: DMA
        wr(A_DMA_MK, 32'hF);
        evt(2'd3, 8'd3, 64'd0, 32'd0);
        tick();
        chk("R9", "irq_dma_on", 64'(irq_dma), 64'd1);
        rd(A_DMA_ST, d);  chk("R9", "dma_status", 64'(d), 64'h8);
        wr(A_DMA_MK, 32'h7);
        tick();
        chk("R9", "irq_dma_masked_off", 64'(irq_dma), 64'd0);

        // R11: fill, overflow, drain
        for (int i = 0; i < DEPTH; i++)
            evt(2'd0, 8'(i), {32'(i * 3), 32'(i ^ 32'h55AA)}, 32'(i * 7 + 1));
        rd(A_LEVEL, d);   chk("R11", "level_full", 64'(d), 64'd128);
        rd(A_MISC_ST, d); chk("R11", "no_overflow_yet", 64'(d), 64'd0);
        wr(A_MISC_MK, 32'd1);
        evt(2'd0, 8'hEE, 64'hFFFF_FFFF_FFFF_FFFF, 32'hFFFF_FFFF);
        rd(A_LEVEL, d);   chk("R11", "level_after_drop", 64'(d), 64'd128);
        rd(A_MISC_ST, d); chk("R11", "overflow_bit", 64'(d), 64'd1);
        tick();
        chk("R11", "irq_misc_on", 64'(irq_misc), 64'd1);
        for (int i = 0; i < DEPTH; i++) pop_check("R11");
        rd(A_LEVEL, d);   chk("R11", "level_drained", 64'(d), 64'd0);
        wr(A_MISC_ST, 32'd1);
        tick();
        chk("R11", "irq_misc_cleared", 64'(irq_misc), 64'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule